// File: doc/BRIEF.md
# CAN Bit Timing Unit

This unit turns a fast system clock into the bit-level timing of a CAN node. A programmable divider produces a time-quantum tick. Every nominal bit is then built from quanta in three parts: a one-quantum synchronization segment, a first timing segment and a second timing segment. The unit emits a transmit enable when a new bit starts. It emits a receive enable, together with the captured line level, at the sample point, which is the boundary between the two timing segments.

The receive line is observed once per quantum. A recessive-to-dominant transition moves the bit grid in one of two ways. If the bus is idle, or the frame logic has enabled hard synchronization, the transition restarts the bit outright. Otherwise it triggers a resynchronization: the first segment is lengthened or the second is shortened, by no more than the programmed jump width, and only once between two sample points. Every detected falling edge exports a signed phase error. Separate one-cycle pulses mark hard-sync events and resync events. Frame decoding, stuffing and error confinement belong to the logic that consumes these enables.

Top module: `cbt_bit_timing`

## Requirements
- R1: `tq_tick` is high for one cycle out of every `cfg_prescale`+1 system cycles. It is high in every cycle when `cfg_prescale` is 0.
- R2: Without edges, a bit lasts 1 + (`cfg_tseg1`+1) + (`cfg_tseg2`+1) quanta. `tx_bit_en` pulses for one cycle, in the cycle after the tick that closes the second segment.
- R3: `rx_sample_en` pulses for one cycle, in the cycle after the tick that closes the first segment. From that cycle on, `rx_bit` holds the level `rx_line` had at that tick. Without edges, the sample point comes (1+`cfg_tseg1`+1) quanta after the bit start.
- R4: A falling edge exists only where `rx_line` is 0 at a tick and was 1 at the previous tick. The line is taken as 1 after reset. A rising edge has no effect on timing and raises no pulse.
- R5: A falling edge seen while `bus_idle` or `hsync_en` is high is a hard sync. The quantum holding the edge becomes the synchronization segment and the next quantum opens the first segment. `hard_sync_pulse` pulses for one cycle and no `tx_bit_en` is raised.
- R6: `phase_err` is a 6-bit two's-complement value, updated one cycle after every falling edge and held otherwise. It is 0 for an edge in the synchronization segment, k+1 for an edge in quantum k of the first segment, and -(`cfg_tseg2`+1-k) for an edge in quantum k of the second segment.
- R7: A resync edge in the first segment lengthens that segment by min(phase error, `cfg_sjw`+1) quanta and pulses `resync_pulse`.
- R8: A resync edge in the second segment shortens that segment by min(|phase error|, `cfg_sjw`+1) quanta and pulses `resync_pulse`. If the cut reaches the edge quantum, that quantum counts as the synchronization segment and `tx_bit_en` pulses at once.
- R9: Only one resync or hard sync is applied between two sample points. Later falling edges in that interval update only `phase_err`, and a hard sync is applied even when a resync has already happened.
- R10: The reset is synchronous and active low. After it, all pulses, `rx_bit` and `phase_err` are 0 and the bit grid starts at the synchronization segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_prescale | input | 8 | Quantum length minus one, in system cycles |
| cfg_tseg1 | input | 4 | First timing segment length minus one (legal 1..15) |
| cfg_tseg2 | input | 3 | Second timing segment length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| rx_line | input | 1 | Receive line from the transceiver, 1 = recessive |
| bus_idle | input | 1 | Bus-idle hint, enables hard sync |
| hsync_en | input | 1 | Hard-sync enable from the frame logic |
| tq_tick | output | 1 | Time-quantum tick |
| tx_bit_en | output | 1 | Start-of-bit enable |
| rx_sample_en | output | 1 | Sample-point enable |
| rx_bit | output | 1 | Line level captured at the last sample point |
| hard_sync_pulse | output | 1 | A hard sync was applied |
| resync_pulse | output | 1 | A resync was applied |
| phase_err | output | 6 | Signed phase error of the last falling edge |

## Verification
`tq_tick` follows the divider state in the same cycle. Every other output is registered and appears in the cycle after the tick that caused it, which means an edge must already be on `rx_line` when that tick's clock edge arrives. The bench drives inputs on the falling clock edge. It advances a behavioural integer model at each rising edge and compares all outputs with the model at the next falling edge, so both sides see the same one-cycle delay. Directed checks measure bit period, tick spacing and the distance from bit start to sample point in cycles, and count the sync pulses within a few cycles of each stimulus.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
// Shared types of the CAN bit timing unit.
package cbt_pkg;
    // Segment of the nominal bit that the current quantum belongs to.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_quantum_gen.sv
`timescale 1ns/1ps
// Quantum divider: raises tick for one cycle out of every prescale+1.
// Assumes prescale is held stable outside reset.
module cbt_quantum_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] prescale,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;

    assign tick = (cnt_q >= prescale);

    // Free-running cycle counter that wraps at the programmed terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (tick)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // R1: with a divider above 1 two ticks never touch
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0) |=> !tick);
endmodule

// File: rtl/cbt_edge_watch.sv
`timescale 1ns/1ps
// Line observer: samples the receive line once per quantum and flags a
// recessive-to-dominant change between two consecutive quantum samples.
// Assumes rx is already synchronous to clk.
module cbt_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    output logic fall_edge
);
    logic rx_tq_q;

    assign fall_edge = tick && rx_tq_q && !rx;

    // Remember the line level seen at the last quantum tick (recessive after reset).
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_tq_q <= 1'b1;
        else if (tick) rx_tq_q <= rx;
    end
endmodule

// File: rtl/cbt_segment_ctrl.sv
`timescale 1ns/1ps
// Segment sequencer: walks quanta through sync, first and second segment,
// applies hard sync and width-limited resync, and emits registered enables.
// Assumes the timing fields stay stable outside reset.
module cbt_segment_ctrl
    import cbt_pkg::*;
#(
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int SJW_W   = 2,
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               fall_edge,
    input  logic               rx,
    input  logic [TSEG1_W-1:0] tseg1,
    input  logic [TSEG2_W-1:0] tseg2,
    input  logic [SJW_W-1:0]   sjw,
    input  logic               bus_idle,
    input  logic               hsync_en,
    output logic               tx_en,
    output logic               rx_en,
    output logic               rx_bit,
    output logic               hard_pulse,
    output logic               resync_pulse,
    output logic [PHASE_W-1:0] phase_err
);
    localparam int CNT_W = $clog2((1 << TSEG1_W) + (1 << SJW_W)) + 1;

    seg_e             seg_q, seg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ext_q, ext_d;
    logic [CNT_W-1:0] cut_q, cut_d;
    logic             lock_q, lock_d;
    logic             tx_d, rx_d;

    logic [CNT_W-1:0] t1_len_m1, t2_len_m1, jump_w;
    logic [CNT_W-1:0] mag_late, mag_early, jump_late, jump_early;
    logic [CNT_W-1:0] ext_eff, cut_eff, t1_end;
    logic [CNT_W:0]   span2;
    logic             do_hard, do_resync;
    logic [PHASE_W-1:0] e_meas;

    assign t1_len_m1  = CNT_W'(tseg1);
    assign t2_len_m1  = CNT_W'(tseg2);
    assign jump_w     = CNT_W'(sjw) + CNT_W'(1);
    assign mag_late   = cnt_q + CNT_W'(1);
    assign mag_early  = t2_len_m1 + CNT_W'(1) - cnt_q;
    assign jump_late  = (mag_late  < jump_w) ? mag_late  : jump_w;
    assign jump_early = (mag_early < jump_w) ? mag_early : jump_w;

    assign do_hard   = fall_edge && (bus_idle || hsync_en);
    assign do_resync = fall_edge && !do_hard && !lock_q && (seg_q != SEG_SYNC);

    assign ext_eff = (do_resync && seg_q == SEG_TS1) ? jump_late  : ext_q;
    assign cut_eff = (do_resync && seg_q == SEG_TS2) ? jump_early : cut_q;
    assign t1_end  = t1_len_m1 + ext_eff;
    assign span2   = {1'b0, cnt_q} + {1'b0, cut_eff};

    // Signed distance of the edge from the expected synchronization quantum.
    always_comb begin
        case (seg_q)
            SEG_TS1: e_meas = PHASE_W'(mag_late);
            SEG_TS2: e_meas = PHASE_W'(0) - PHASE_W'(mag_early);
            default: e_meas = '0;
        endcase
    end

    // Next quantum position, segment adjustment and enable requests.
    always_comb begin
        seg_d  = seg_q;
        cnt_d  = cnt_q;
        ext_d  = ext_q;
        cut_d  = cut_q;
        lock_d = lock_q;
        tx_d   = 1'b0;
        rx_d   = 1'b0;
        if (tick) begin
            if (do_hard) begin
                seg_d  = SEG_TS1;
                cnt_d  = '0;
                ext_d  = '0;
                cut_d  = '0;
                lock_d = 1'b1;
            end else begin
                case (seg_q)
                    SEG_SYNC: begin
                        seg_d = SEG_TS1;
                        cnt_d = '0;
                        ext_d = '0;
                    end
                    SEG_TS1: begin
                        if (cnt_q == t1_end) begin
                            seg_d  = SEG_TS2;
                            cnt_d  = '0;
                            ext_d  = '0;
                            cut_d  = '0;
                            lock_d = 1'b0;
                            rx_d   = 1'b1;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                            ext_d = ext_eff;
                            if (do_resync) lock_d = 1'b1;
                        end
                    end
                    default: begin
                        if (do_resync) lock_d = 1'b1;
                        if (span2 > {1'b0, t2_len_m1}) begin
                            seg_d = SEG_TS1;
                            cnt_d = '0;
                            ext_d = '0;
                            cut_d = '0;
                            tx_d  = 1'b1;
                        end else if (span2 == {1'b0, t2_len_m1}) begin
                            seg_d = SEG_SYNC;
                            cnt_d = '0;
                            cut_d = '0;
                            tx_d  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                            cut_d = cut_eff;
                        end
                    end
                endcase
            end
        end
    end

    // Register the bit-grid state and the one-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q        <= SEG_SYNC;
            cnt_q        <= '0;
            ext_q        <= '0;
            cut_q        <= '0;
            lock_q       <= 1'b0;
            tx_en        <= 1'b0;
            rx_en        <= 1'b0;
            rx_bit       <= 1'b0;
            hard_pulse   <= 1'b0;
            resync_pulse <= 1'b0;
            phase_err    <= '0;
        end else begin
            seg_q        <= seg_d;
            cnt_q        <= cnt_d;
            ext_q        <= ext_d;
            cut_q        <= cut_d;
            lock_q       <= lock_d;
            tx_en        <= tx_d;
            rx_en        <= rx_d;
            hard_pulse   <= do_hard;
            resync_pulse <= do_resync;
            if (rx_d)      rx_bit    <= rx;
            if (fall_edge) phase_err <= e_meas;
        end
    end

    // R2: a bit start is only announced after a quantum tick
    a_r2_tx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> $past(tick));
    // R3: a sample point is only announced after a quantum tick
    a_r3_rx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> $past(tick));
    // R3: bit start and sample point never coincide
    a_r3_tx_rx_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en));
    // R5: hard sync and resync are exclusive
    a_r5_sync_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_pulse && resync_pulse));
    // R6: phase error only moves after a detected falling edge
    a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_edge) |-> $stable(phase_err));
    // R7: a resync always follows a falling edge
    a_r7_resync_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> $past(fall_edge));
endmodule

// File: rtl/cbt_bit_timing.sv
`timescale 1ns/1ps
// CAN bit timing unit: quantum divider, line observer and segment sequencer.
// Assumes configuration changes only while rst_n is low.
module cbt_bit_timing #(
    parameter int PRESC_W = 8,
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int SJW_W   = 2,
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_prescale,
    input  logic [TSEG1_W-1:0] cfg_tseg1,
    input  logic [TSEG2_W-1:0] cfg_tseg2,
    input  logic [SJW_W-1:0]   cfg_sjw,
    input  logic               rx_line,
    input  logic               bus_idle,
    input  logic               hsync_en,
    output logic               tq_tick,
    output logic               tx_bit_en,
    output logic               rx_sample_en,
    output logic               rx_bit,
    output logic               hard_sync_pulse,
    output logic               resync_pulse,
    output logic [PHASE_W-1:0] phase_err
);
    logic fall_edge;

    cbt_quantum_gen #(.PRESC_W(PRESC_W)) u_quantum (
        .clk      (clk),
        .rst_n    (rst_n),
        .prescale (cfg_prescale),
        .tick     (tq_tick)
    );

    cbt_edge_watch u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tq_tick),
        .rx        (rx_line),
        .fall_edge (fall_edge)
    );

    cbt_segment_ctrl #(
        .TSEG1_W (TSEG1_W),
        .TSEG2_W (TSEG2_W),
        .SJW_W   (SJW_W),
        .PHASE_W (PHASE_W)
    ) u_segment (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tq_tick),
        .fall_edge    (fall_edge),
        .rx           (rx_line),
        .tseg1        (cfg_tseg1),
        .tseg2        (cfg_tseg2),
        .sjw          (cfg_sjw),
        .bus_idle     (bus_idle),
        .hsync_en     (hsync_en),
        .tx_en        (tx_bit_en),
        .rx_en        (rx_sample_en),
        .rx_bit       (rx_bit),
        .hard_pulse   (hard_sync_pulse),
        .resync_pulse (resync_pulse),
        .phase_err    (phase_err)
    );
endmodule

// File: tb/cbt_bit_timing_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural quantum/segment model compared on every clock, plus
// directed scenarios for period, sample point, hard sync and resync.
module cbt_bit_timing_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] presc = 8'd1;
    logic [3:0] tseg1 = 4'd5;
    logic [2:0] tseg2 = 3'd3;
    logic [1:0] sjw = 2'd1;
    logic       rx = 1'b1;
    logic       idle = 1'b0;
    logic       hs = 1'b0;
    logic       tq_tick, tx_bit_en, rx_sample_en, rx_bit, hard_sync_pulse, resync_pulse;
    logic [5:0] phase_err;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    int n_hard = 0;
    int n_res = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    cbt_bit_timing dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(presc), .cfg_tseg1(tseg1),
        .cfg_tseg2(tseg2), .cfg_sjw(sjw), .rx_line(rx), .bus_idle(idle),
        .hsync_en(hs), .tq_tick(tq_tick), .tx_bit_en(tx_bit_en),
        .rx_sample_en(rx_sample_en), .rx_bit(rx_bit),
        .hard_sync_pulse(hard_sync_pulse), .resync_pulse(resync_pulse),
        .phase_err(phase_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Behavioural model: integers for segment (0 sync, 1 first, 2 second) and position
    int m_pc, m_seg, m_pos, m_ext, m_cut, m_jw, m_t1len, m_t2len;
    bit m_lock, m_rxq, m_tk, m_edge, m_hard, m_res;
    bit e_tx, e_rx, e_bit, e_hard, e_res;
    int e_ph;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_seg = 0; m_pos = 0; m_ext = 0; m_cut = 0;
            m_lock = 0; m_rxq = 1;
            e_tx = 0; e_rx = 0; e_bit = 0; e_hard = 0; e_res = 0; e_ph = 0;
        end else begin
            e_tx = 0; e_rx = 0; e_hard = 0; e_res = 0;
            m_tk = (m_pc == int'(presc));
            m_pc = m_tk ? 0 : m_pc + 1;
            if (m_tk) begin
                m_edge = m_rxq && !rx;
                m_rxq  = rx;
                m_jw   = int'(sjw) + 1;
                m_hard = m_edge && (idle || hs);
                m_res  = m_edge && !m_hard && !m_lock && (m_seg != 0);
                if (m_edge)
                    e_ph = (m_seg == 0) ? 0 : (m_seg == 1) ? m_pos + 1 : -(int'(tseg2) + 1 - m_pos);
                e_hard = m_hard;
                e_res  = m_res;
                if (m_hard) begin
                    m_seg = 1; m_pos = 0; m_ext = 0; m_cut = 0; m_lock = 1;
                end else if (m_seg == 0) begin
                    m_seg = 1; m_pos = 0; m_ext = 0;
                end else if (m_seg == 1) begin
                    if (m_res) begin
                        m_ext = (m_pos + 1 < m_jw) ? m_pos + 1 : m_jw;
                        m_lock = 1;
                    end
                    m_t1len = int'(tseg1) + 1 + m_ext;
                    if (m_pos == m_t1len - 1) begin
                        m_seg = 2; m_pos = 0; m_ext = 0; m_cut = 0; m_lock = 0;
                        e_rx = 1; e_bit = rx;
                    end else m_pos++;
                end else begin
                    if (m_res) begin
                        m_cut = (int'(tseg2) + 1 - m_pos < m_jw) ? int'(tseg2) + 1 - m_pos : m_jw;
                        m_lock = 1;
                    end
                    m_t2len = int'(tseg2) + 1 - m_cut;
                    if (m_pos >= m_t2len) begin
                        m_seg = 1; m_pos = 0; m_ext = 0; m_cut = 0; e_tx = 1;
                    end else if (m_pos == m_t2len - 1) begin
                        m_seg = 0; m_pos = 0; m_cut = 0; e_tx = 1;
                    end else m_pos++;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            cyc++;
            if (hard_sync_pulse) n_hard++;
            if (resync_pulse) n_res++;
            check(tq_tick == (m_pc == int'(presc)), "R1 tq_tick", tq_tick, int'(m_pc == int'(presc)));
            check(tx_bit_en == e_tx, "R2 tx_bit_en", tx_bit_en, e_tx);
            check(rx_sample_en == e_rx, "R3 rx_sample_en", rx_sample_en, e_rx);
            check(rx_bit == e_bit, "R3 rx_bit", rx_bit, e_bit);
            check(hard_sync_pulse == e_hard, "R5 hard_sync_pulse", hard_sync_pulse, e_hard);
            check(resync_pulse == e_res, "R7 R8 resync_pulse", resync_pulse, e_res);
            check($signed(phase_err) == e_ph, "R6 phase_err", $signed(phase_err), e_ph);
            if (cyc > 150000) begin
                n_err++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
                $finish;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tx();
        @(negedge clk);
        while (!tx_bit_en) @(negedge clk);
    endtask

    task automatic bit_period(output int p);
        int t0;
        wait_tx();
        t0 = cyc;
        wait_tx();
        p = cyc - t0;
    endtask

    initial begin
        int cnt, p, t0, r0, h0;
        logic [15:0] lf;
        @(negedge clk);
        started = 1;
        step(4);
        // R10: reset state of all outputs
        check({tx_bit_en, rx_sample_en, rx_bit, hard_sync_pulse, resync_pulse} == 5'b0,
              "R10 reset pulses", int'({tx_bit_en, rx_sample_en, rx_bit, hard_sync_pulse, resync_pulse}), 0);
        check(phase_err == 6'd0, "R10 reset phase", int'(phase_err), 0);
        rst_n = 1'b1;

        // R1: 20 ticks in 40 cycles with a divider of 2
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tq_tick) cnt++;
        end
        check(cnt == 20, "R1 tick count", cnt, 20);

        // R2: (1+6+4) quanta of 2 cycles
        bit_period(p);
        check(p == 22, "R2 bit period", p, 22);

        // R3: sample point 7 quanta after the bit start
        wait_tx();
        t0 = cyc;
        @(negedge clk);
        while (!rx_sample_en) @(negedge clk);
        check(cyc - t0 == 14, "R3 sample offset", cyc - t0, 14);

        // R5: falling edge on an idle bus
        step(30);
        idle = 1'b1;
        step(7);
        h0 = n_hard; r0 = n_res;
        rx = 1'b0;
        step(6);
        check(n_hard - h0 == 1, "R5 hard sync on idle", n_hard - h0, 1);
        check(n_res == r0, "R5 no resync on hard sync", n_res - r0, 0);
        idle = 1'b0;
        step(40);
        rx = 1'b1;
        step(60);

        // R7: late edge in the first segment
        r0 = n_res;
        wait_tx();
        step(6);
        rx = 1'b0;
        step(6);
        check(n_res - r0 == 1, "R7 late resync", n_res - r0, 1);
        check($signed(phase_err) > 0, "R6 late phase sign", $signed(phase_err), 1);
        step(60);
        rx = 1'b1;
        step(60);

        // R8: early edge in the second segment
        r0 = n_res;
        wait_tx();
        step(18);
        rx = 1'b0;
        step(4);
        check(n_res - r0 == 1, "R8 early resync", n_res - r0, 1);
        check($signed(phase_err) == -2, "R6 early phase value", $signed(phase_err), -2);
        step(60);
        rx = 1'b1;
        step(60);

        // R9: two falling edges before one sample point
        r0 = n_res;
        wait_tx();
        step(4); rx = 1'b0;
        step(4); rx = 1'b1;
        step(4); rx = 1'b0;
        step(4);
        check(n_res - r0 == 1, "R9 single resync", n_res - r0, 1);
        step(60);

        // R4: rising edge only
        wait_tx();
        r0 = n_res; h0 = n_hard;
        step(6);
        rx = 1'b1;
        bit_period(p);
        check(p == 22, "R4 period after rising edge", p, 22);
        check(n_res == r0 && n_hard == h0, "R4 rising edge ignored", (n_res - r0) + (n_hard - h0), 0);

        // R2 minimum grid and R5 through the hard-sync enable
        rst_n = 1'b0;
        presc = 8'd0; tseg1 = 4'd1; tseg2 = 3'd0; sjw = 2'd3;
        step(3);
        rst_n = 1'b1;
        bit_period(p);
        check(p == 4, "R2 minimum bit period", p, 4);
        hs = 1'b1;
        step(3);
        h0 = n_hard;
        rx = 1'b0;
        step(3);
        check(n_hard - h0 == 1, "R5 hard sync enable", n_hard - h0, 1);
        hs = 1'b0;
        step(20);
        rx = 1'b1;
        step(20);

        // Mixed line activity against the model (R6 R7 R8 R9)
        rst_n = 1'b0;
        presc = 8'd2; tseg1 = 4'd7; tseg2 = 3'd4; sjw = 2'd2;
        step(3);
        rst_n = 1'b1;
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3:0] == 4'd0) rx = ~rx;
            idle = (lf[9:6] == 4'd0);
        end
        idle = 1'b0;
        step(10);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule